// File: doc/BRIEF.md
# PCIe Error Signaling and Logging Controller

This block takes error events detected elsewhere in a PCIe endpoint or bridge and turns them into sticky status bits, a captured packet header with a first-error pointer, and requests to send an error message upstream. Each event is a one-cycle pulse. It carries the index of the uncorrectable error it reports, a flag saying that the agent was acting as a completer returning an unsupported-request completion, and the header of the offending packet. Software reads the block's registers through a read port. It configures the block and clears status bits through a write port.

Classification follows the PCIe signaling rules. Suppose an unsupported request is non-fatal by its severity bit and was seen while completing. That case is advisory: it goes down the correctable path and asks for ERR_COR instead of ERR_NONFATAL. Every other uncorrectable error sets the fatal-detected or non-fatal-detected status according to its severity bit. It then asks for the matching message only when it is unmasked and reporting is enabled. Pending message requests wait in a small priority store until the downstream message builder accepts them through a valid/ready handshake. An ECRC error also raises a one-cycle drop indication for the packet.

Register map, as read-port and write-port addresses: 0 device control, 1 device status, 2 uncorrectable status, 3 uncorrectable mask, 4 uncorrectable severity, 5 correctable status, 6 correctable mask, 7 first error pointer, and 8 to 11 header log dwords 0 to 3.

Top module: `err_report_ctrl`

## Requirements
- R1: After reset the following are all zero: control, every status register, both masks, the first error pointer, the header log, drop_pkt and msg_valid. Uncorrectable severity resets to 32'h0006_2030, so bits 19 and 20 are 0 (non-fatal) and bit 4 is 1 (fatal).
- R2: The cycle after an event with index b, uncorrectable status bit b is set. For an ECRC event (b = 19), drop_pkt is also high for exactly that one cycle.
- R3: Any event with index 20 (unsupported request) sets device status bit 3 one cycle later.
- R4: An event with index 20, completer flag 1 and severity bit 20 = 0 is advisory. It sets correctable status bit 13 and device status bit 0. It never sets device status bit 1 and never requests ERR_NONFATAL. It requests ERR_COR only when control bit 0 is 1 and correctable mask bit 13 is 0.
- R5: With control bit 0 = 0, an advisory event requests no message, but it still sets device status bit 0 and correctable status bit 13.
- R6: A non-advisory event sets device status bit 2 when its severity bit is 1, and bit 1 when its severity bit is 0.
- R7: A non-advisory event that is not masked requests ERR_FATAL when its severity bit is 1 and ERR_NONFATAL when it is 0. The request is made only if the matching control bit (bit 2 fatal, bit 1 non-fatal) or the SERR enable (control bit 8) is 1. Control keeps only bits 0, 1, 2 and 8 of a write.
- R8: Device status bits [3:0], uncorrectable status and correctable status are write-1-to-clear. A 0 written to any of them has no effect. When a set and a clear hit the same bit in the same cycle, the set wins.
- R9: An event whose uncorrectable mask bit is 1 still sets its status bits. It requests no message and leaves the first error pointer and the header log unchanged.
- R10: An unmasked event loads its index into the first error pointer and its header into the header log. This happens only when the uncorrectable status bit named by the pointer is clear, after this cycle's clear is applied. While that bit stays set, both are held.
- R11: The message port offers one request per type at a time, with fatal first, then non-fatal, then correctable (msg_type 2, 1, 0). A request stays offered until msg_ready accepts it. While waiting, the offered type can only move up in priority.
- R12: Registers are read and written at the addresses listed above. The first error pointer and the header log are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One-cycle error event pulse |
| ev_bit | input | 5 | Uncorrectable status index of the event |
| ev_cpl | input | 1 | Agent was a completer returning an unsupported-request completion |
| ev_hdr | input | 128 | Header of the offending packet, dword 0 in the low bits |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| drop_pkt | output | 1 | Drop the packet that carried an ECRC error |
| msg_valid | output | 1 | An error message request is offered |
| msg_type | output | 2 | 0 ERR_COR, 1 ERR_NONFATAL, 2 ERR_FATAL |
| msg_ready | input | 1 | Downstream accepts the offered request |

## Verification
The assertions check these rules on every cycle:
- an unsupported request always flags device status;
- an ECRC error always drops its packet;
- an advisory event never raises a non-fatal request or the non-fatal-detected bit;
- a masked event and a fully disabled reporting path stay silent;
- the first error pointer and the header log stay frozen while their status bit is set;
- an offered message never falls to a lower priority before it is accepted.

Only the bench scenarios can show the rest: the exact contents of every register after mixed sequences of events, writes and handshakes. This covers write-1-to-clear racing with a new event, pointer reload after software clears the logged error, and the full fatal, non-fatal, correctable drain order.

// File: rtl/err_report_pkg.sv
`timescale 1ns/1ps
package err_report_pkg;

    localparam int ERR_W     = 32;
    localparam int ERR_IDX_W = 5;

    // Uncorrectable / correctable bit positions decoded by software
    localparam int UE_ECRC_BIT = 19;
    localparam int UE_UR_BIT   = 20;
    localparam int CE_ADV_BIT  = 13;

    // Control bits
    localparam int CTL_CE_EN   = 0;
    localparam int CTL_NF_EN   = 1;
    localparam int CTL_FE_EN   = 2;
    localparam int CTL_SERR_EN = 8;

    // Device status bits
    localparam int DS_CED = 0;
    localparam int DS_NFD = 1;
    localparam int DS_FED = 2;
    localparam int DS_URD = 3;
    localparam int DS_W   = 4;

    // Message request slots, index == priority
    localparam int MSG_NTYPE = 3;
    typedef enum logic [1:0] {
        MSG_COR      = 2'd0,
        MSG_NONFATAL = 2'd1,
        MSG_FATAL    = 2'd2
    } msg_e;

    // Register addresses
    localparam int A_CTRL    = 0;
    localparam int A_DSTS    = 1;
    localparam int A_UE_STS  = 2;
    localparam int A_UE_MASK = 3;
    localparam int A_UE_SEV  = 4;
    localparam int A_CE_STS  = 5;
    localparam int A_CE_MASK = 6;
    localparam int A_FEP     = 7;
    localparam int A_HDR0    = 8;

endpackage

// File: rtl/err_classify.sv
`timescale 1ns/1ps
module err_classify
    import err_report_pkg::*;
#(
    parameter int UE_W  = ERR_W,
    parameter int IDX_W = ERR_IDX_W
) (
    input  logic              ev_valid,
    input  logic [IDX_W-1:0]  ev_bit,
    input  logic              ev_cpl,
    input  logic              ce_en,
    input  logic              nf_en,
    input  logic              fe_en,
    input  logic              serr_en,
    input  logic [UE_W-1:0]   ue_mask,
    input  logic [UE_W-1:0]   ue_sev,
    input  logic              ce_adv_mask,
    input  logic              log_free,
    output logic [UE_W-1:0]   ue_set,
    output logic [ERR_W-1:0]  ce_set,
    output logic [DS_W-1:0]   ds_set,
    output logic [MSG_NTYPE-1:0] req,
    output logic              advisory,
    output logic              log_en,
    output logic              drop
);

    logic is_ur;
    logic masked;
    logic sev_fatal;

    always_comb begin
        is_ur     = (ev_bit == IDX_W'(UE_UR_BIT));
        masked    = ue_mask[ev_bit];
        sev_fatal = ue_sev[ev_bit];
        advisory  = ev_valid && is_ur && ev_cpl && !ue_sev[UE_UR_BIT];

        ue_set = '0;
        ce_set = '0;
        ds_set = '0;
        req    = '0;
        log_en = 1'b0;
        drop   = 1'b0;

        if (ev_valid) begin
            ue_set[ev_bit] = 1'b1;
            drop           = (ev_bit == IDX_W'(UE_ECRC_BIT));
            log_en         = !masked && log_free;
            if (is_ur) begin
                ds_set[DS_URD] = 1'b1;
            end
            if (advisory) begin
                ce_set[CE_ADV_BIT] = 1'b1;
                ds_set[DS_CED]     = 1'b1;
                req[MSG_COR]       = ce_en && !ce_adv_mask;
            end else if (sev_fatal) begin
                ds_set[DS_FED]     = 1'b1;
                req[MSG_FATAL]     = !masked && (fe_en || serr_en);
            end else begin
                ds_set[DS_NFD]     = 1'b1;
                req[MSG_NONFATAL]  = !masked && (nf_en || serr_en);
            end
        end
    end

endmodule

// File: rtl/err_msg_arb.sv
`timescale 1ns/1ps
module err_msg_arb #(
    parameter int NTYPE = 3,
    localparam int TW   = (NTYPE > 1) ? $clog2(NTYPE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTYPE-1:0] req,
    input  logic             ready,
    output logic             valid,
    output logic [TW-1:0]    mtype,
    output logic [NTYPE-1:0] pend
);

    typedef struct packed {
        logic [NTYPE-1:0] pend;
    } arb_t;

    arb_t             d, q;
    logic [NTYPE-1:0] grant;

    always_comb begin
        d     = q;
        grant = '0;
        mtype = '0;
        // highest index is highest priority: later iterations override
        for (int i = 0; i < NTYPE; i++) begin
            if (q.pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                mtype    = TW'(i);
            end
        end
        valid  = |q.pend;
        d.pend = (q.pend & ~(ready ? grant : '0)) | req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pend = q.pend;

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid) else $error("request dropped before accept"); // R11

    AST_PRIO_ONLY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> mtype >= $past(mtype)) else $error("offered type fell in priority"); // R11

endmodule

// File: rtl/err_report_ctrl.sv
`timescale 1ns/1ps
module err_report_ctrl
    import err_report_pkg::*;
#(
    parameter int          HDR_DW     = 4,
    parameter int          ADDR_W     = 4,
    parameter logic [31:0] UE_SEV_RST = 32'h0006_2030,
    parameter logic [31:0] CTRL_WMASK = 32'h0000_0107
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_valid,
    input  logic [ERR_IDX_W-1:0]  ev_bit,
    input  logic                  ev_cpl,
    input  logic [HDR_DW*32-1:0]  ev_hdr,
    input  logic                  reg_wr_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic [ADDR_W-1:0]     reg_rd_addr,
    output logic [31:0]           reg_rdata,
    output logic                  drop_pkt,
    output logic                  msg_valid,
    output logic [1:0]            msg_type,
    input  logic                  msg_ready
);

    localparam int HDR_BASE = A_HDR0;

    typedef struct packed {
        logic [31:0]              ctrl;
        logic [DS_W-1:0]          dsts;
        logic [ERR_W-1:0]         ue_sts;
        logic [ERR_W-1:0]         ue_mask;
        logic [ERR_W-1:0]         ue_sev;
        logic [ERR_W-1:0]         ce_sts;
        logic [ERR_W-1:0]         ce_mask;
        logic [ERR_IDX_W-1:0]     fep;
        logic [HDR_DW-1:0][31:0]  hdr;
        logic                     drop;
    } regs_t;

    regs_t d, q;

    // write decode
    logic wr_ctrl, wr_ds, wr_ue, wr_uemask, wr_uesev, wr_ce, wr_cemask;
    logic [ERR_W-1:0] ue_clr, ce_clr, ue_keep;
    logic [DS_W-1:0]  ds_clr;
    logic             log_free;

    assign wr_ctrl   = reg_wr_en && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_ds     = reg_wr_en && (reg_addr == ADDR_W'(A_DSTS));
    assign wr_ue     = reg_wr_en && (reg_addr == ADDR_W'(A_UE_STS));
    assign wr_uemask = reg_wr_en && (reg_addr == ADDR_W'(A_UE_MASK));
    assign wr_uesev  = reg_wr_en && (reg_addr == ADDR_W'(A_UE_SEV));
    assign wr_ce     = reg_wr_en && (reg_addr == ADDR_W'(A_CE_STS));
    assign wr_cemask = reg_wr_en && (reg_addr == ADDR_W'(A_CE_MASK));

    assign ue_clr   = wr_ue ? reg_wdata : '0;
    assign ce_clr   = wr_ce ? reg_wdata : '0;
    assign ds_clr   = wr_ds ? reg_wdata[DS_W-1:0] : '0;
    assign ue_keep  = q.ue_sts & ~ue_clr;
    assign log_free = !ue_keep[q.fep];

    // classification
    logic [ERR_W-1:0]     ue_set, ce_set;
    logic [DS_W-1:0]      ds_set;
    logic [MSG_NTYPE-1:0] req;
    logic                 advisory, log_en, drop_now;

    err_classify #(
        .UE_W  (ERR_W),
        .IDX_W (ERR_IDX_W)
    ) u_cls (
        .ev_valid    (ev_valid),
        .ev_bit      (ev_bit),
        .ev_cpl      (ev_cpl),
        .ce_en       (q.ctrl[CTL_CE_EN]),
        .nf_en       (q.ctrl[CTL_NF_EN]),
        .fe_en       (q.ctrl[CTL_FE_EN]),
        .serr_en     (q.ctrl[CTL_SERR_EN]),
        .ue_mask     (q.ue_mask),
        .ue_sev      (q.ue_sev),
        .ce_adv_mask (q.ce_mask[CE_ADV_BIT]),
        .log_free    (log_free),
        .ue_set      (ue_set),
        .ce_set      (ce_set),
        .ds_set      (ds_set),
        .req         (req),
        .advisory    (advisory),
        .log_en      (log_en),
        .drop        (drop_now)
    );

    // message request store
    logic [MSG_NTYPE-1:0] pend;

    err_msg_arb #(
        .NTYPE (MSG_NTYPE)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .ready (msg_ready),
        .valid (msg_valid),
        .mtype (msg_type),
        .pend  (pend)
    );

    // next state
    always_comb begin
        d = q;
        if (wr_ctrl)   d.ctrl    = reg_wdata & CTRL_WMASK;
        if (wr_uemask) d.ue_mask = reg_wdata;
        if (wr_uesev)  d.ue_sev  = reg_wdata;
        if (wr_cemask) d.ce_mask = reg_wdata;

        // sticky status: clear first, then set, so a new event wins
        d.ue_sts = ue_keep | ue_set;
        d.ce_sts = (q.ce_sts & ~ce_clr) | ce_set;
        d.dsts   = (q.dsts & ~ds_clr) | ds_set;

        if (log_en) begin
            d.fep = ev_bit;
            for (int i = 0; i < HDR_DW; i++) begin
                d.hdr[i] = ev_hdr[i*32 +: 32];
            end
        end
        d.drop = drop_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.ue_sev <= UE_SEV_RST;
        end else begin
            q <= d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_rd_addr)
            ADDR_W'(A_CTRL):    reg_rdata = q.ctrl;
            ADDR_W'(A_DSTS):    reg_rdata = 32'(q.dsts);
            ADDR_W'(A_UE_STS):  reg_rdata = q.ue_sts;
            ADDR_W'(A_UE_MASK): reg_rdata = q.ue_mask;
            ADDR_W'(A_UE_SEV):  reg_rdata = q.ue_sev;
            ADDR_W'(A_CE_STS):  reg_rdata = q.ce_sts;
            ADDR_W'(A_CE_MASK): reg_rdata = q.ce_mask;
            ADDR_W'(A_FEP):     reg_rdata = 32'(q.fep);
            default: begin
                for (int i = 0; i < HDR_DW; i++) begin
                    if (reg_rd_addr == ADDR_W'(HDR_BASE + i)) reg_rdata = q.hdr[i];
                end
            end
        endcase
    end

    assign drop_pkt = q.drop;

    // assertions
    AST_UR_FLAGS_DSTS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_bit == ERR_IDX_W'(UE_UR_BIT) |=> q.dsts[DS_URD])
        else $error("UR did not set detected bit"); // R3

    AST_ECRC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_bit == ERR_IDX_W'(UE_ECRC_BIT) |=> drop_pkt)
        else $error("ECRC packet not dropped"); // R2

    AST_ADVISORY_NO_NONFATAL: assert property (@(posedge clk) disable iff (!rst_n)
        advisory && !pend[MSG_NONFATAL] && !q.dsts[DS_NFD] && !wr_ds
        |=> !pend[MSG_NONFATAL] && !q.dsts[DS_NFD])
        else $error("advisory case raised non-fatal"); // R4

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !advisory && q.ue_mask[ev_bit] && pend == '0
        |=> pend == '0 && $stable(q.fep) && $stable(q.hdr))
        else $error("masked error produced message or log"); // R9

    AST_REPORT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !advisory && !q.ctrl[CTL_NF_EN] && !q.ctrl[CTL_FE_EN]
        && !q.ctrl[CTL_SERR_EN] && !pend[MSG_NONFATAL] && !pend[MSG_FATAL]
        |=> !pend[MSG_NONFATAL] && !pend[MSG_FATAL])
        else $error("uncorrectable message sent while disabled"); // R7

    AST_FIRST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        q.ue_sts[q.fep] && !ue_clr[q.fep] |=> $stable(q.fep) && $stable(q.hdr))
        else $error("first error log overwritten"); // R10

endmodule

// File: tb/err_report_ctrl_tb.sv
`timescale 1ns/1ps
module err_report_ctrl_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ev_valid;
    logic [4:0]   ev_bit;
    logic         ev_cpl;
    logic [127:0] ev_hdr;
    logic         reg_wr_en;
    logic [3:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [3:0]   reg_rd_addr;
    logic [31:0]  reg_rdata;
    logic         drop_pkt;
    logic         msg_valid;
    logic [1:0]   msg_type;
    logic         msg_ready;

    always #4 clk = ~clk;

    err_report_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_bit(ev_bit), .ev_cpl(ev_cpl),
        .ev_hdr(ev_hdr), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata), .drop_pkt(drop_pkt),
        .msg_valid(msg_valid), .msg_type(msg_type), .msg_ready(msg_ready)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag;

    // reference model, built from the requirements
    logic [31:0] m_ctrl, m_ue, m_uemask, m_uesev, m_ce, m_cemask;
    logic [3:0]  m_ds;
    logic [4:0]  m_fep;
    logic [31:0] m_hdr [4];
    logic [2:0]  m_pend;
    logic        m_drop;

    function automatic logic [31:0] exp_reg(int a);
        case (a)
            0: return m_ctrl;
            1: return {28'd0, m_ds};
            2: return m_ue;
            3: return m_uemask;
            4: return m_uesev;
            5: return m_ce;
            6: return m_cemask;
            7: return {27'd0, m_fep};
            default: return m_hdr[a-8];
        endcase
    endfunction

    function automatic logic [1:0] exp_type();
        if (m_pend[2]) return 2'd2;
        if (m_pend[1]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int a = 0; a < 12; a++) begin
            reg_rd_addr = 4'(a);
            #0.1;
            check($sformatf("reg%0d", a), reg_rdata, exp_reg(a));
        end
        check("msg_valid", {31'd0, msg_valid}, {31'd0, |m_pend});
        if (m_pend != 3'd0) check("msg_type", {30'd0, msg_type}, {30'd0, exp_type()});
        check("drop_pkt", {31'd0, drop_pkt}, {31'd0, m_drop});
    endtask

    task automatic model_reset();
        m_ctrl = '0; m_ue = '0; m_uemask = '0; m_uesev = 32'h0006_2030;
        m_ce = '0; m_cemask = '0; m_ds = '0; m_fep = '0; m_pend = '0; m_drop = 1'b0;
        for (int i = 0; i < 4; i++) m_hdr[i] = '0;
    endtask

    // one clock: drive inputs, predict, clock, compare
    task automatic op(input bit ev, input int b = 0, input bit cpl = 0,
                      input logic [127:0] hdr = '0, input bit wr = 0,
                      input int wa = 0, input logic [31:0] wd = '0, input bit rdy = 0);
        logic [31:0] n_ctrl, n_ue, n_uemask, n_uesev, n_ce, n_cemask;
        logic [3:0]  n_ds;
        logic [4:0]  n_fep;
        logic [2:0]  n_pend;
        logic        adv, free;
        ev_valid = ev; ev_bit = 5'(b); ev_cpl = cpl; ev_hdr = hdr;
        reg_wr_en = wr; reg_addr = 4'(wa); reg_wdata = wd; msg_ready = rdy;

        n_ctrl = m_ctrl; n_ue = m_ue; n_uemask = m_uemask; n_uesev = m_uesev;
        n_ce = m_ce; n_cemask = m_cemask; n_ds = m_ds; n_fep = m_fep; n_pend = m_pend;
        if (rdy && m_pend != 3'd0) n_pend[exp_type()] = 1'b0;
        if (wr) begin
            case (wa)
                0: n_ctrl   = wd & 32'h107;
                1: n_ds     = n_ds & ~wd[3:0];
                2: n_ue     = n_ue & ~wd;
                3: n_uemask = wd;
                4: n_uesev  = wd;
                5: n_ce     = n_ce & ~wd;
                6: n_cemask = wd;
                default: ;
            endcase
        end
        free = !n_ue[m_fep];
        if (ev) begin
            adv = (b == 20) && cpl && !m_uesev[20];
            n_ue[b] = 1'b1;
            if (b == 20) n_ds[3] = 1'b1;
            if (adv) begin
                n_ce[13] = 1'b1; n_ds[0] = 1'b1;
                if (m_ctrl[0] && !m_cemask[13]) n_pend[0] = 1'b1;
            end else if (m_uesev[b]) begin
                n_ds[2] = 1'b1;
                if (!m_uemask[b] && (m_ctrl[2] || m_ctrl[8])) n_pend[2] = 1'b1;
            end else begin
                n_ds[1] = 1'b1;
                if (!m_uemask[b] && (m_ctrl[1] || m_ctrl[8])) n_pend[1] = 1'b1;
            end
            if (!m_uemask[b] && free) begin
                n_fep = 5'(b);
                for (int i = 0; i < 4; i++) m_hdr[i] = hdr[i*32 +: 32];
            end
        end
        @(posedge clk);
        m_ctrl = n_ctrl; m_ue = n_ue; m_uemask = n_uemask; m_uesev = n_uesev;
        m_ce = n_ce; m_cemask = n_cemask; m_ds = n_ds; m_fep = n_fep; m_pend = n_pend;
        m_drop = ev && (b == 19);
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_all();
        op(0, 0, 0, '0, 1, 1, 32'hF, 1);
        op(0, 0, 0, '0, 1, 2, 32'hFFFF_FFFF, 1);
        op(0, 0, 0, '0, 1, 5, 32'hFFFF_FFFF, 1);
        op(0, 0, 0, '0, 0, 0, '0, 1);
        op(0, 0, 0, '0, 0, 0, '0, 1);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 1'b0; ev_valid = 0; ev_bit = 0; ev_cpl = 0; ev_hdr = '0;
        reg_wr_en = 0; reg_addr = 0; reg_wdata = 0; reg_rd_addr = 0; msg_ready = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; compare_all();

        tag = "R12";                                   // map and write mask of control
        op(0, 0, 0, '0, 1, 0, 32'hFFFF_FFFF);
        op(0, 0, 0, '0, 1, 7, 32'hFFFF_FFFF);          // read-only pointer ignores write
        op(0, 0, 0, '0, 1, 0, 32'h0000_0001);

        tag = "R4";                                    // advisory UR -> ERR_COR only
        op(1, 20, 1, {4{32'hA5A5_0001}});
        op(0);
        tag = "R11"; op(0, 0, 0, '0, 0, 0, '0, 1);

        tag = "R5"; clear_all();
        op(0, 0, 0, '0, 1, 0, 32'h0);
        op(1, 20, 1, {4{32'h0000_0B0B}});

        tag = "R7"; clear_all();
        op(1, 20, 0, {4{32'h1111_2222}});              // non-advisory, reporting off
        op(0, 0, 0, '0, 1, 0, 32'h100);                // SERR enable
        op(1, 19, 0, {4{32'h3333_4444}});
        tag = "R2"; op(0, 0, 0, '0, 0, 0, '0, 1);

        tag = "R6"; clear_all();
        op(0, 0, 0, '0, 1, 4, 32'h0016_2030);          // UR fatal
        op(1, 20, 1, {4{32'h5555_6666}});
        op(0, 0, 0, '0, 1, 4, 32'h0006_2030, 1);

        tag = "R9"; clear_all();
        op(0, 0, 0, '0, 1, 3, 32'h0008_0000);
        op(1, 19, 0, {4{32'hDEAD_BEEF}});
        op(0, 0, 0, '0, 1, 3, 32'h0);

        tag = "R10"; clear_all();
        op(1, 5, 0, {4{32'hAAAA_0005}});
        op(1, 6, 0, {4{32'hBBBB_0006}});
        op(0, 0, 0, '0, 1, 2, 32'h0000_0020);          // clear the logged bit
        op(1, 6, 0, {4{32'hCCCC_0006}});

        tag = "R8";
        op(0, 0, 0, '0, 1, 2, 32'h0);
        op(1, 7, 0, '0, 1, 2, 32'h0000_0080);          // set wins over clear
        op(0, 0, 0, '0, 1, 1, 32'h0);
        op(0, 0, 0, '0, 1, 1, 32'hF);

        tag = "R11"; clear_all();
        op(0, 0, 0, '0, 1, 0, 32'h107);
        op(1, 20, 1, {4{32'h0C0C_0C0C}});
        op(1, 19, 0, {4{32'h0D0D_0D0D}});
        op(1, 4, 0, {4{32'h0E0E_0E0E}});
        op(0); op(0, 0, 0, '0, 0, 0, '0, 1);
        op(0, 0, 0, '0, 0, 0, '0, 1); op(0, 0, 0, '0, 0, 0, '0, 1);

        tag = "R2/R3/R4/R6/R7/R10/R11 random";
        for (int it = 0; it < 3000; it++) begin
            int          pick, b, wa;
            bit          ev, wr;
            logic [31:0] wd;
            pick = $urandom_range(0, 3);
            b    = (pick == 0) ? 19 : (pick == 3) ? $urandom_range(0, 31) : 20;
            ev   = ($urandom_range(0, 1) == 1);
            wr   = ($urandom_range(0, 4) == 0);
            wa   = $urandom_range(0, 6);
            wd   = $urandom();
            if (wa == 3 || wa == 6 || wa == 4) wd = wd & $urandom();
            op(ev, b, $urandom_range(0, 1) == 1, {$urandom(), $urandom(), $urandom(), $urandom()},
               wr, wa, wd, $urandom_range(0, 1) == 1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule